// File: doc/BRIEF.md
# Auto-Negotiation Page Register Logic

This block holds the management-visible registers that surround the page exchange of Ethernet auto-negotiation. When the negotiation engine delivers a received code word, the block stores it. A base page goes to the partner-ability register and a next page goes to the partner-next-page register. The block also raises sticky status flags that software clears by reading the status register. Software therefore never mistakes an old code word for a new one. A new negotiation wipes these flags, together with the record of whether the partner can exchange next pages.

On the transmit side, software writes the next page it wants to send into a transmit register. That write raises a pending indication. The negotiation engine consumes the indication when it sends the page. The block inserts the toggle bit itself, so that consecutive transmitted next pages always alternate.

The management port reads combinationally. Any side effect of a read or a write appears from the following clock cycle.

Top module: `an_page_regs`

## Requirements
- R1: An accepted base page stores its 16-bit word at address 5. An accepted next page stores its word at address 8. Either value reads back from the cycle after the strobe.
- R2: Status register 6 bit 1 (page received) sets after any accepted page and stays set until register 6 is read. Register 16 bit 1 always shows the same value.
- R3: A read of address 6 returns the current flags and clears bits 1 and 2 from the next cycle on. If a page is accepted in the same cycle as that read, the set wins and the flag stays asserted.
- R4: Register 6 bit 2 sets when an accepted base page has bit 15 (next page) at 1. It stays set until register 6 is read.
- R5: Register 6 bit 5 reads 1 when the last accepted page was a base page and 0 when it was a next page.
- R6: A negotiation restart clears register 6 bits 1, 2 and 5, the register 16 mirror and the exchange permission. A page strobe in the same cycle as a restart is ignored. Registers 5, 7 and 8 keep their contents.
- R7: np_exchange_ok is 1 only when loc_np_able is 1 and the last base page accepted since restart had bit 15 at 1. While it is 0, a next page strobe changes neither register 8 nor any flag.
- R8: A write to address 7 stores the word, which reads back unchanged, and sets np_pending from the next cycle. np_tx_taken clears np_pending only while it is set. A write in the same cycle as np_tx_taken leaves np_pending at 1.
- R9: np_tx_word equals register 7 with bit 11 replaced by the toggle. After reset or restart the toggle is the inverse of loc_base_toggle. Each accepted np_tx_taken flips it.
- R10: Reads of any address other than 5, 6, 7, 8 and 16 return 0. Writes to any address other than 7 are ignored. Reads of addresses other than 6 have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pg_rx_stb | input | 1 | A code word was received this cycle |
| pg_rx_word | input | 16 | Received code word |
| pg_rx_is_base | input | 1 | 1 = received word is a base page, 0 = next page |
| neg_restart | input | 1 | Pulse marking the start of a new negotiation |
| loc_np_able | input | 1 | Local base page advertises next page ability |
| loc_base_toggle | input | 1 | Bit 11 of the local base page |
| mgmt_addr | input | 5 | Management register address |
| mgmt_rd | input | 1 | Read strobe (drives the clear-on-read side effect) |
| mgmt_wr | input | 1 | Write strobe |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Combinational read data for mgmt_addr |
| np_tx_taken | input | 1 | The engine sent the pending next page |
| np_tx_word | output | 16 | Next page word to transmit, toggle bit inserted |
| np_pending | output | 1 | A written next page waits to be sent |
| np_exchange_ok | output | 1 | Both sides allow next page exchange |

## Verification
Read data and np_tx_word are combinational, so the bench checks them in the same cycle that it sets the address. Every register, flag, pending bit and toggle update becomes visible exactly one clock edge after its cause. The bench drives its inputs just after the falling edge and samples one nanosecond later. It advances its reference model once per rising edge, so each comparison sees the state left by the previous cycle. The two same-cycle collisions, a read of the status register against a strobe and a restart against a strobe, are driven directly and checked in the cycle that follows.

// File: rtl/an_page_pkg.sv
package an_page_pkg;

   typedef struct packed {
      logic page_rcvd;
      logic lp_np_able;
      logic rx_is_base;
   } an_stat_t;

   function automatic bit bit_ok(int pos, int width);
      return (pos >= 0) && (pos < width);
   endfunction

endpackage

// File: rtl/an_rx_capture.sv
module an_rx_capture #(
   parameter int DW    = 16,
   parameter int B_NP  = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb,
   input  logic [DW-1:0] word,
   input  logic          is_base,
   input  logic          restart,
   input  logic          loc_np_able,
   output logic [DW-1:0] base_word,
   output logic [DW-1:0] np_word,
   output logic          acc_base,
   output logic          acc_np,
   output logic          exch_ok
);
   logic lp_base_np_q;

   assign exch_ok  = loc_np_able & lp_base_np_q;
   assign acc_base = stb & is_base & ~restart;
   assign acc_np   = stb & ~is_base & ~restart & exch_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_word    <= '0;
         np_word      <= '0;
         lp_base_np_q <= 1'b0;
      end else begin
         if (restart) lp_base_np_q <= 1'b0;
         else if (acc_base) lp_base_np_q <= word[B_NP];
         if (acc_base) base_word <= word;
         if (acc_np) np_word <= word;
      end
   end
endmodule

// File: rtl/an_sticky_status.sv
module an_sticky_status
   import an_page_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     acc_base,
   input  logic     acc_np,
   input  logic     base_np_bit,
   input  logic     rd_clear,
   input  logic     restart,
   output an_stat_t stat
);
   an_stat_t stat_q, stat_n;

   always_comb begin
      stat_n = stat_q;
      if (restart) begin
         stat_n = '0;
      end else begin
         if (rd_clear) begin
            stat_n.page_rcvd  = 1'b0;
            stat_n.lp_np_able = 1'b0;
         end
         if (acc_base || acc_np) stat_n.page_rcvd = 1'b1;
         if (acc_base && base_np_bit) stat_n.lp_np_able = 1'b1;
         if (acc_base) stat_n.rx_is_base = 1'b1;
         else if (acc_np) stat_n.rx_is_base = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_n;
   end

   assign stat = stat_q;
endmodule

// File: rtl/an_tx_np.sv
module an_tx_np #(
   parameter int DW    = 16,
   parameter int B_TOG = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          taken,
   input  logic          restart,
   input  logic          loc_tog,
   output logic [DW-1:0] stored,
   output logic [DW-1:0] tx_word,
   output logic          pending
);
   logic first_q, tog_q, tog_cur, take_ok;

   assign tog_cur = first_q ? ~loc_tog : tog_q;
   assign take_ok = taken & pending;

   always_comb begin
      tx_word        = stored;
      tx_word[B_TOG] = tog_cur;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stored  <= '0;
         pending <= 1'b0;
         first_q <= 1'b1;
         tog_q   <= 1'b0;
      end else begin
         if (wr) stored <= wdata;
         if (wr) pending <= 1'b1;
         else if (take_ok) pending <= 1'b0;
         if (restart) begin
            first_q <= 1'b1;
         end else if (take_ok) begin
            first_q <= 1'b0;
            tog_q   <= ~tog_cur;
         end
      end
   end
endmodule

// File: rtl/an_page_regs.sv
module an_page_regs
   import an_page_pkg::*;
#(
   parameter int DW        = 16,
   parameter int ADDR_W    = 5,
   parameter int A_LP_BASE = 5,
   parameter int A_STATUS  = 6,
   parameter int A_TX_NP   = 7,
   parameter int A_LP_NP   = 8,
   parameter int A_MIRROR  = 16,
   parameter int B_PRX     = 1,
   parameter int B_LPNP    = 2,
   parameter int B_ISBASE  = 5,
   parameter int B_MIRROR  = 1,
   parameter int B_NP      = 15,
   parameter int B_TOGGLE  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pg_rx_stb,
   input  logic [DW-1:0]     pg_rx_word,
   input  logic              pg_rx_is_base,
   input  logic              neg_restart,
   input  logic              loc_np_able,
   input  logic              loc_base_toggle,
   input  logic [ADDR_W-1:0] mgmt_addr,
   input  logic              mgmt_rd,
   input  logic              mgmt_wr,
   input  logic [DW-1:0]     mgmt_wdata,
   output logic [DW-1:0]     mgmt_rdata,
   input  logic              np_tx_taken,
   output logic [DW-1:0]     np_tx_word,
   output logic              np_pending,
   output logic              np_exchange_ok
);
   localparam int NREG = 1 << ADDR_W;

   generate
      if (!bit_ok(B_PRX, DW) || !bit_ok(B_LPNP, DW) || !bit_ok(B_ISBASE, DW) ||
          !bit_ok(B_MIRROR, DW) || !bit_ok(B_NP, DW) || !bit_ok(B_TOGGLE, DW)) begin : g_bad_bit
         $error("status or code word bit position outside data width");
      end
      if (!bit_ok(A_LP_BASE, NREG) || !bit_ok(A_STATUS, NREG) || !bit_ok(A_TX_NP, NREG) ||
          !bit_ok(A_LP_NP, NREG) || !bit_ok(A_MIRROR, NREG)) begin : g_bad_addr
         $error("register address outside address space");
      end
      if (B_PRX == B_LPNP || B_PRX == B_ISBASE || B_LPNP == B_ISBASE) begin : g_bad_overlap
         $error("status flag positions overlap");
      end
   endgenerate

   logic          rd_status, wr_txnp;
   logic          acc_base, acc_np;
   logic [DW-1:0] lp_base_word, lp_np_word, tx_stored;
   logic [DW-1:0] status_word, mirror_word;
   an_stat_t      stat;
   logic          prx_q, lpnp_q;

   assign rd_status = mgmt_rd & (mgmt_addr == A_STATUS[ADDR_W-1:0]);
   assign wr_txnp   = mgmt_wr & (mgmt_addr == A_TX_NP[ADDR_W-1:0]);

   an_rx_capture #(.DW(DW), .B_NP(B_NP)) u_rx (
      .clk, .rst_n,
      .stb(pg_rx_stb), .word(pg_rx_word), .is_base(pg_rx_is_base),
      .restart(neg_restart), .loc_np_able,
      .base_word(lp_base_word), .np_word(lp_np_word),
      .acc_base, .acc_np, .exch_ok(np_exchange_ok)
   );

   an_sticky_status u_stat (
      .clk, .rst_n, .acc_base, .acc_np,
      .base_np_bit(pg_rx_word[B_NP]), .rd_clear(rd_status),
      .restart(neg_restart), .stat
   );

   an_tx_np #(.DW(DW), .B_TOG(B_TOGGLE)) u_tx (
      .clk, .rst_n, .wr(wr_txnp), .wdata(mgmt_wdata),
      .taken(np_tx_taken), .restart(neg_restart), .loc_tog(loc_base_toggle),
      .stored(tx_stored), .tx_word(np_tx_word), .pending(np_pending)
   );

   assign prx_q  = stat.page_rcvd;
   assign lpnp_q = stat.lp_np_able;

   for (genvar i = 0; i < DW; i++) begin : g_stat_bits
      if (i == B_PRX) begin : g_prx
         assign status_word[i] = stat.page_rcvd;
      end else if (i == B_LPNP) begin : g_lpnp
         assign status_word[i] = stat.lp_np_able;
      end else if (i == B_ISBASE) begin : g_base
         assign status_word[i] = stat.rx_is_base;
      end else begin : g_zero
         assign status_word[i] = 1'b0;
      end
      if (i == B_MIRROR) begin : g_mir
         assign mirror_word[i] = stat.page_rcvd;
      end else begin : g_mzero
         assign mirror_word[i] = 1'b0;
      end
   end

   always_comb begin
      if      (mgmt_addr == A_LP_BASE[ADDR_W-1:0]) mgmt_rdata = lp_base_word;
      else if (mgmt_addr == A_STATUS[ADDR_W-1:0])  mgmt_rdata = status_word;
      else if (mgmt_addr == A_TX_NP[ADDR_W-1:0])   mgmt_rdata = tx_stored;
      else if (mgmt_addr == A_LP_NP[ADDR_W-1:0])   mgmt_rdata = lp_np_word;
      else if (mgmt_addr == A_MIRROR[ADDR_W-1:0])  mgmt_rdata = mirror_word;
      else                                         mgmt_rdata = '0;
   end
endmodule

// File: rtl/an_page_regs_chk.sv
module an_page_regs_chk #(
   parameter int DW    = 16,
   parameter int B_TOG = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pg_rx_stb,
   input logic          pg_rx_is_base,
   input logic          neg_restart,
   input logic          rd_status,
   input logic          wr_txnp,
   input logic          np_tx_taken,
   input logic          np_pending,
   input logic [DW-1:0] np_tx_word,
   input logic          np_exchange_ok,
   input logic          prx_q,
   input logic          lpnp_q
);
   AST_BASE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_rx_stb && pg_rx_is_base && !neg_restart) |=> prx_q); // R2
   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (prx_q && !rd_status && !neg_restart) |=> prx_q); // R2
   AST_SET_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && pg_rx_stb && pg_rx_is_base && !neg_restart) |=> prx_q); // R3
   AST_RESTART_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
      neg_restart |=> (!prx_q && !lpnp_q && !np_exchange_ok)); // R6
   AST_NP_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_rx_stb && !pg_rx_is_base && !np_exchange_ok && !prx_q && !neg_restart) |=> !prx_q); // R7
   AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_txnp |=> np_pending); // R8
   AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (np_tx_taken && np_pending && !neg_restart) |=> (np_tx_word[B_TOG] != $past(np_tx_word[B_TOG]))); // R9
endmodule

bind an_page_regs an_page_regs_chk #(.DW(DW), .B_TOG(B_TOGGLE)) u_chk (
   .clk(clk), .rst_n(rst_n), .pg_rx_stb(pg_rx_stb), .pg_rx_is_base(pg_rx_is_base),
   .neg_restart(neg_restart), .rd_status(rd_status), .wr_txnp(wr_txnp),
   .np_tx_taken(np_tx_taken), .np_pending(np_pending), .np_tx_word(np_tx_word),
   .np_exchange_ok(np_exchange_ok), .prx_q(prx_q), .lpnp_q(lpnp_q)
);

// File: tb/an_page_regs_test.sv
`timescale 1ns/1ps
module an_page_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pg_rx_stb = 0, pg_rx_is_base = 0, neg_restart = 0;
   logic [15:0] pg_rx_word = '0;
   logic        loc_np_able = 0, loc_base_toggle = 0;
   logic [4:0]  mgmt_addr = '0;
   logic        mgmt_rd = 0, mgmt_wr = 0, np_tx_taken = 0;
   logic [15:0] mgmt_wdata = '0;
   logic [15:0] mgmt_rdata, np_tx_word;
   logic        np_pending, np_exchange_ok;

   int errors = 0, checks = 0;
   bit done = 0;

   // reference model state
   logic [15:0] m5 = 0, m7 = 0, m8 = 0;
   logic        prx = 0, lpnp = 0, isb = 0, bnp = 0, pend = 0, first = 1, tog = 0;

   always #2.5 clk = ~clk;

   an_page_regs uut (.*);

   function automatic logic [15:0] exp_rd(logic [4:0] a);
      case (a)
         5'd5:  return m5;
         5'd6:  return {10'b0, isb, 2'b0, lpnp, prx, 1'b0};
         5'd7:  return m7;
         5'd8:  return m8;
         5'd16: return {14'b0, prx, 1'b0};
         default: return 16'h0;
      endcase
   endfunction

   function automatic logic cur_tog();
      return first ? ~loc_base_toggle : tog;
   endfunction

   function automatic string tag_for(logic [4:0] a);
      case (a)
         5'd5, 5'd8: return "R1";
         5'd6:  return "R2/R3/R4/R5/R6";
         5'd7:  return "R8";
         5'd16: return "R2";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      logic acc_b, acc_n, tk;
      acc_b = pg_rx_stb & pg_rx_is_base & ~neg_restart;
      acc_n = pg_rx_stb & ~pg_rx_is_base & ~neg_restart & loc_np_able & bnp;
      tk = np_tx_taken & pend;
      if (neg_restart) begin
         prx = 0; lpnp = 0; isb = 0; bnp = 0;
      end else begin
         if (mgmt_rd && mgmt_addr == 5'd6) begin prx = 0; lpnp = 0; end
         if (acc_b) begin m5 = pg_rx_word; bnp = pg_rx_word[15]; prx = 1; isb = 1;
            if (pg_rx_word[15]) lpnp = 1; end
         if (acc_n) begin m8 = pg_rx_word; prx = 1; isb = 0; end
      end
      if (mgmt_wr && mgmt_addr == 5'd7) begin m7 = mgmt_wdata; pend = 1; end
      else if (tk) pend = 0;
      if (neg_restart) first = 1;
      else if (tk) begin tog = ~cur_tog(); first = 0; end
   endtask

   // inputs already driven after the falling edge: check, advance model, wait
   task automatic step();
      logic [15:0] etx;
      #1;
      chk(mgmt_rdata === exp_rd(mgmt_addr), tag_for(mgmt_addr), mgmt_rdata, exp_rd(mgmt_addr));
      etx = m7; etx[11] = cur_tog();
      chk(np_tx_word === etx, "R9", np_tx_word, etx);
      chk(np_pending === pend, "R8", {15'b0, np_pending}, {15'b0, pend});
      chk(np_exchange_ok === (loc_np_able & bnp), "R7", {15'b0, np_exchange_ok},
          {15'b0, loc_np_able & bnp});
      model_edge();
      @(negedge clk);
   endtask

   task automatic idle();
      pg_rx_stb = 0; neg_restart = 0; mgmt_rd = 0; mgmt_wr = 0; np_tx_taken = 0;
   endtask

   task automatic rx(logic base, logic [15:0] w);
      idle(); pg_rx_stb = 1; pg_rx_is_base = base; pg_rx_word = w; step();
   endtask

   task automatic rd(logic [4:0] a);
      idle(); mgmt_rd = 1; mgmt_addr = a; step();
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0973));
      repeat (3) @(negedge clk);
      // reset state
      #1;
      chk(mgmt_rdata === 16'h0 && np_pending === 0, "R2 reset", mgmt_rdata, 16'h0);
      chk(np_tx_word[11] === 1'b1, "R9 reset toggle", np_tx_word, 16'h0800);
      rst_n = 1;
      @(negedge clk);

      loc_np_able = 1; loc_base_toggle = 0;
      // R7: next page before any base page is ignored
      rx(0, 16'h1234); rd(5'd8); rd(5'd6);
      // R1/R4/R5: base page with NP, then read status
      rx(1, 16'hC1E1); rd(5'd6); rd(5'd6); rd(5'd5);
      // R3: read of status colliding with a page
      idle(); mgmt_rd = 1; mgmt_addr = 5'd6; pg_rx_stb = 1; pg_rx_is_base = 0;
      pg_rx_word = 16'hA55A; step();
      rd(5'd6); rd(5'd16); rd(5'd8);
      // R6: restart colliding with a page
      idle(); neg_restart = 1; pg_rx_stb = 1; pg_rx_is_base = 1; pg_rx_word = 16'h8001;
      step(); rd(5'd6); rd(5'd5);
      // R8/R9: write, take, take without pending, write with take
      idle(); mgmt_wr = 1; mgmt_addr = 5'd7; mgmt_wdata = 16'hFFFF; step();
      idle(); np_tx_taken = 1; step(); step(); rd(5'd7);
      idle(); mgmt_wr = 1; mgmt_addr = 5'd7; mgmt_wdata = 16'h2003; step();
      idle(); mgmt_wr = 1; mgmt_wdata = 16'h0005; np_tx_taken = 1; step();
      // R10: writes elsewhere ignored, unmapped reads zero
      idle(); mgmt_wr = 1; mgmt_addr = 5'd5; mgmt_wdata = 16'hDEAD; step(); rd(5'd5);
      rd(5'd3); rd(5'd31);

      for (int i = 0; i < 4000; i++) begin
         int r;
         idle();
         pg_rx_stb = ($urandom % 100) < 30;
         pg_rx_is_base = ($urandom % 100) < 40;
         pg_rx_word = 16'($urandom);
         neg_restart = ($urandom % 100) < 3;
         if (($urandom % 100) < 5) begin
            loc_np_able = ($urandom % 4) != 0;
            loc_base_toggle = 1'($urandom);
         end
         r = $urandom % 8;
         mgmt_addr = (r < 6) ? 5'(r + 3) : (r == 6 ? 5'd16 : 5'($urandom));
         mgmt_rd = ($urandom % 100) < 40;
         mgmt_wr = ($urandom % 100) < 12;
         mgmt_wdata = 16'($urandom);
         np_tx_taken = ($urandom % 100) < 20;
         step();
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule